// File: doc/BRIEF.md
# LIN-Capable UART Transmitter

This block serialises one character per data write onto a single transmit line that rests high. The frame has a low start bit, 5 to 9 data bits sent least significant bit first, an optional parity bit and one or two high stop bits. An external baud tick sets the pace, and each bit lasts from one tick to the next.

A header command that comes with the write can turn the write into a bus-master header instead of a character. The header is either a break alone, or a break followed by the sync character 0x55 and then an identifier taken from the written data. The frame settings are captured at the moment the write is taken, so a header or character finishes with the settings it started with. Dropping the enable stops new writes from being taken but never cuts short work already in progress.

Top module: `lin_uart_tx`

## Requirements
- R1: After reset, and whenever `busy` is 0, `txd` is 1.
- R2: A write (`wr_valid`=1) is taken only when `tx_enable`=1 and `busy`=0. `busy` rises on the next clock and `txd` goes to 0 on that clock. Any other write is ignored, including one made while `busy`=1.
- R3: A character frame is a 0 start bit followed by the data bits, least significant bit first. The count of data bits comes from `cfg_size`: 0 gives 8, 1 gives 9, 5, 6 and 7 give 5, 6 and 7, and the reserved codes 2 to 4 give 8.
- R4: When `cfg_parity_en`=1, one parity bit follows the data. With `cfg_parity_odd`=0 the data bits plus the parity bit hold an even number of ones, and with `cfg_parity_odd`=1 they hold an odd number.
- R5: `cfg_two_stop`=0 gives one high stop bit and 1 gives two. `busy` falls on the clock that takes the baud tick ending the last stop bit.
- R6: `cfg_hdr_cmd`=1 sends a break: BREAK_BITS (13 by default) bit times of 0, then a single delimiter bit of 1. The written data is not sent.
- R7: `cfg_hdr_cmd`=2 sends a break, then 0x55, then `wr_data[7:0]` as the identifier, with no gaps between them. Both characters use 8 data bits, no parity and one stop bit, whatever the other settings are. `cfg_hdr_cmd`=3 acts as 0, which is a plain character.
- R8: Setting `tx_enable` to 0 while `busy`=1 does not shorten the running character or header.
- R9: `txd` changes only on a clock edge that sees `baud_tick`=1, or on the clock that takes a write.
- R10: Changing the settings or `wr_data` after a write has been taken has no effect on that character or header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse that ends each bit time |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | 9 | Character data, or the identifier in its low 8 bits |
| cfg_size | input | 3 | Character size code |
| cfg_parity_en | input | 1 | Enables the parity bit |
| cfg_parity_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| cfg_two_stop | input | 1 | 0 selects one stop bit, 1 selects two |
| cfg_hdr_cmd | input | 2 | 0 or 3 plain character, 1 break, 2 full header |
| tx_enable | input | 1 | Allows new writes to be taken |
| txd | output | 1 | Serial output, high when idle |
| busy | output | 1 | High while a character or header is being sent |

## Verification
The assertions check these rules on every cycle: the line is high whenever the block is idle, a taken write drives the line low on the next clock, a disabled write leaves the block idle, `txd` holds its value between baud ticks, `busy` is not dropped in the middle of a frame, and the sync field starts right after the break. The bench scenarios are needed for the rest: the exact bit patterns for each size code, parity sense and stop-bit count, the full three-field header, and the proof that settings changed in mid-frame, an enable dropped in mid-frame and a write made while busy all leave the output unchanged.

// File: rtl/lin_uart_tx_pkg.sv
package lin_uart_tx_pkg;
  localparam int MAX_W = 32;
  localparam int LEN_W = 6;

  typedef enum logic [1:0] {K_CHAR, K_BREAK, K_SYNC, K_IDENT} kind_e;

  typedef struct packed {
    logic [MAX_W-1:0] bits;
    logic [LEN_W-1:0] len;
  } frame_t;

  function automatic logic [3:0] size_bits(input logic [2:0] code);
    case (code)
      3'd1:    return 4'd9;
      3'd5:    return 4'd5;
      3'd6:    return 4'd6;
      3'd7:    return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic parity_of(input logic [8:0] d, input logic [3:0] n,
                                     input logic odd);
    logic       p;
    logic [8:0] s;
    p = odd;
    s = d;
    for (int i = 0; i < 9; i++) begin
      if (i < int'(n)) p = p ^ s[0];
      s = s >> 1;
    end
    return p;
  endfunction

  function automatic frame_t char_frame(input logic [8:0] d, input logic [3:0] n,
                                        input logic pe, input logic odd,
                                        input logic two);
    frame_t     f;
    logic [4:0] pos;
    logic [8:0] s;
    f.bits    = '1;
    f.bits[0] = 1'b0;
    pos       = 5'd1;
    s         = d;
    for (int i = 0; i < 9; i++) begin
      if (i < int'(n)) begin
        f.bits[pos] = s[0];
        pos         = pos + 5'd1;
      end
      s = s >> 1;
    end
    if (pe) begin
      f.bits[pos] = parity_of(d, n, odd);
      pos         = pos + 5'd1;
    end
    pos   = pos + (two ? 5'd2 : 5'd1);
    f.len = {1'b0, pos};
    return f;
  endfunction

  function automatic frame_t break_frame(input int low);
    frame_t f;
    f.bits = {MAX_W{1'b1}} << low;
    f.len  = LEN_W'(low + 1);
    return f;
  endfunction
endpackage

// File: rtl/lin_uart_tx_framer.sv
module lin_uart_tx_framer
  import lin_uart_tx_pkg::*;
#(
  parameter int BREAK_BITS = 13
) (
  input  kind_e       kind,
  input  logic [8:0]  data,
  input  logic [2:0]  size_code,
  input  logic        par_en,
  input  logic        par_odd,
  input  logic        two_stop,
  output frame_t      frame
);
  always_comb begin
    case (kind)
      K_BREAK: frame = break_frame(BREAK_BITS);
      K_SYNC:  frame = char_frame(9'h055, 4'd8, 1'b0, 1'b0, 1'b0);
      K_IDENT: frame = char_frame({1'b0, data[7:0]}, 4'd8, 1'b0, 1'b0, 1'b0);
      default: frame = char_frame(data, size_bits(size_code), par_en, par_odd, two_stop);
    endcase
  end
endmodule

// File: rtl/lin_uart_tx_shifter.sv
module lin_uart_tx_shifter #(
  parameter int W  = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [W-1:0]  frame_bits,
  input  logic [LW-1:0] frame_len,
  output logic          txd,
  output logic          active,
  output logic          done
);
  logic [W-1:0]  sh;
  logic [LW-1:0] cnt;

  assign active = (cnt != '0);
  assign done   = tick && (cnt == LW'(1));
  assign txd    = active ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '1;
      cnt <= '0;
    end else if (load) begin
      sh  <= frame_bits;
      cnt <= frame_len;
    end else if (tick && active) begin
      sh  <= {1'b1, sh[W-1:1]};
      cnt <= cnt - LW'(1);
    end
  end

  // R9: the line holds its level between baud ticks
  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(txd));
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx
  import lin_uart_tx_pkg::*;
#(
  parameter int BREAK_BITS = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       wr_valid,
  input  logic [8:0] wr_data,
  input  logic [2:0] cfg_size,
  input  logic       cfg_parity_en,
  input  logic       cfg_parity_odd,
  input  logic       cfg_two_stop,
  input  logic [1:0] cfg_hdr_cmd,
  input  logic       tx_enable,
  output logic       txd,
  output logic       busy
);
  typedef enum logic [2:0] {ST_IDLE, ST_CHAR, ST_BREAK, ST_SYNC, ST_IDENT} state_e;

  state_e     state, nxt;
  logic [8:0] data_q;
  logic [2:0] size_q;
  logic       pe_q, odd_q, two_q;
  logic [1:0] hdr_q;

  logic       accept, load, frame_done, shifter_active;
  kind_e      kind;
  frame_t     frame;

  assign busy   = (state != ST_IDLE);
  assign accept = wr_valid && tx_enable && !busy;

  always_comb begin
    nxt  = state;
    load = 1'b0;
    if (accept) begin
      nxt  = (cfg_hdr_cmd == 2'd1 || cfg_hdr_cmd == 2'd2) ? ST_BREAK : ST_CHAR;
      load = 1'b1;
    end else if (frame_done) begin
      case (state)
        ST_BREAK: begin
          nxt  = (hdr_q == 2'd2) ? ST_SYNC : ST_IDLE;
          load = (hdr_q == 2'd2);
        end
        ST_SYNC: begin
          nxt  = ST_IDENT;
          load = 1'b1;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (nxt)
      ST_BREAK: kind = K_BREAK;
      ST_SYNC:  kind = K_SYNC;
      ST_IDENT: kind = K_IDENT;
      default:  kind = K_CHAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      data_q <= '0;
      size_q <= '0;
      pe_q   <= 1'b0;
      odd_q  <= 1'b0;
      two_q  <= 1'b0;
      hdr_q  <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        data_q <= wr_data;
        size_q <= cfg_size;
        pe_q   <= cfg_parity_en;
        odd_q  <= cfg_parity_odd;
        two_q  <= cfg_two_stop;
        hdr_q  <= cfg_hdr_cmd;
      end
    end
  end

  lin_uart_tx_framer #(.BREAK_BITS(BREAK_BITS)) u_framer (
    .kind      (kind),
    .data      (accept ? wr_data : data_q),
    .size_code (accept ? cfg_size : size_q),
    .par_en    (accept ? cfg_parity_en : pe_q),
    .par_odd   (accept ? cfg_parity_odd : odd_q),
    .two_stop  (accept ? cfg_two_stop : two_q),
    .frame     (frame)
  );

  lin_uart_tx_shifter #(.W(MAX_W), .LW(LEN_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .load       (load),
    .frame_bits (frame.bits),
    .frame_len  (frame.len),
    .txd        (txd),
    .active     (shifter_active),
    .done       (frame_done)
  );

  // R1: an idle block keeps the line high and its shifter empty
  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd && !shifter_active));
  // R2: a taken write starts a low start bit or break at once
  assert_accept_starts_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !txd));
  // R2: a write without enable leaves the block idle
  assert_disabled_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !tx_enable && !busy) |=> !busy);
  // R7: the sync field follows the break without a gap
  assert_sync_follows_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BREAK && frame_done && hdr_q == 2'd2) |=> (state == ST_SYNC && !txd));
  // R8: busy falls only at the end of a frame, whatever the enable does
  assert_no_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> busy);
endmodule

// File: tb/lin_uart_tx_test.sv
module lin_uart_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int BRK = 13;
  localparam int NVEC = 9;
  // {size[2:0], parity_en, parity_odd, two_stop, hdr_cmd[1:0], data[8:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 9'h0A5},
    {3'd1, 1'b1, 1'b0, 1'b0, 2'd0, 9'h1C3},
    {3'd5, 1'b1, 1'b1, 1'b1, 2'd0, 9'h015},
    {3'd6, 1'b1, 1'b0, 1'b1, 2'd0, 9'h02A},
    {3'd7, 1'b1, 1'b1, 1'b0, 2'd0, 9'h07F},
    {3'd3, 1'b1, 1'b0, 1'b0, 2'd0, 9'h0F0},
    {3'd0, 1'b0, 1'b0, 1'b0, 2'd1, 9'h033},
    {3'd1, 1'b1, 1'b1, 1'b1, 2'd2, 9'h1A5},
    {3'd0, 1'b0, 1'b1, 1'b0, 2'd3, 9'h081}
  };

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic [2:0] cfg_size = '0;
  logic cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0, cfg_two_stop = 1'b0;
  logic [1:0] cfg_hdr_cmd = '0;
  logic tx_enable = 1'b0;
  logic txd, busy;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_uart_tx uut (.*);

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic add_bit(inout logic [63:0] e, inout int n, input logic b);
    e[n[5:0]] = b;
    n++;
  endtask

  task automatic add_char(inout logic [63:0] e, inout int n, input logic [8:0] d,
                          input int w, input logic pe, input logic odd, input logic two);
    logic [8:0] mask;
    int ones;
    mask = (9'h1 << w) - 9'h1;
    ones = $countones(d & mask);
    add_bit(e, n, 1'b0);
    for (int k = 0; k < w; k++) add_bit(e, n, d[k[3:0]]);
    if (pe) add_bit(e, n, ones[0] ^ odd);
    add_bit(e, n, 1'b1);
    if (two) add_bit(e, n, 1'b1);
  endtask

  task automatic expect_bits(input logic [16:0] v, output logic [63:0] e, output int n);
    int w;
    e = '1;
    n = 0;
    case (v[16:14])
      3'd1: w = 9;
      3'd5: w = 5;
      3'd6: w = 6;
      3'd7: w = 7;
      default: w = 8;
    endcase
    if (v[10:9] == 2'd1 || v[10:9] == 2'd2) begin
      for (int k = 0; k < BRK; k++) add_bit(e, n, 1'b0);
      add_bit(e, n, 1'b1);
      if (v[10:9] == 2'd2) begin
        add_char(e, n, 9'h055, 8, 1'b0, 1'b0, 1'b0);
        add_char(e, n, {1'b0, v[7:0]}, 8, 1'b0, 1'b0, 1'b0);
      end
    end else begin
      add_char(e, n, v[8:0], w, v[13], v[12], v[11]);
    end
  endtask

  // Drives one write on a negedge and follows the whole frame bit by bit.
  task automatic run_frame(input logic [16:0] v, input bit disturb, input string tag);
    logic [63:0] e, got;
    int n;
    bit stable_ok, busy_ok;
    expect_bits(v, e, n);
    got = '1;
    stable_ok = 1'b1;
    busy_ok = 1'b1;
    {cfg_size, cfg_parity_en, cfg_parity_odd, cfg_two_stop, cfg_hdr_cmd, wr_data} = v;
    tx_enable = 1'b1;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      got[i[5:0]] = txd;
      busy_ok &= (busy === 1'b1);
      @(negedge clk);
      if (disturb && i == 0) begin
        // R10 R8 R2: new settings, enable dropped, and a write while busy
        cfg_size = 3'd5; cfg_parity_en = ~v[13]; cfg_parity_odd = ~v[12];
        cfg_two_stop = ~v[11]; cfg_hdr_cmd = 2'd1; wr_data = ~v[8:0];
        tx_enable = 1'b0;
        wr_valid = 1'b1;
      end
      stable_ok &= (txd === got[i[5:0]]);
      @(negedge clk);
      wr_valid = 1'b0;
      stable_ok &= (txd === got[i[5:0]]);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
    check(got === e, {tag, " bit pattern"}, got, e);
    check(busy_ok, {tag, " R8 busy held through frame"}, 64'(busy_ok), 64'd1);
    check(stable_ok, {tag, " R9 line stable between ticks"}, 64'(stable_ok), 64'd1);
    check(busy === 1'b0 && txd === 1'b1, {tag, " R5 R1 idle after last stop bit"},
          {62'd0, busy, txd}, 64'd1);
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && txd === 1'b1, {tag, " R2 no extra frame afterwards"},
          {62'd0, busy, txd}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0, "R1 reset state", {62'd0, busy, txd}, 64'd1);

    // Table walk covering R3 R4 R5 R6 R7
    for (int j = 0; j < NVEC; j++) run_frame(VEC[j], 1'b0, $sformatf("R3 R4 R5 R6 R7 vec%0d", j));

    // R2: write with enable low is ignored
    tx_enable = 1'b0;
    wr_data = 9'h000;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (3) begin
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      check(busy === 1'b0 && txd === 1'b1, "R2 disabled write ignored",
            {62'd0, busy, txd}, 64'd1);
    end

    // R10 R8: disturbances during a character and during a full header
    run_frame({3'd6, 1'b1, 1'b1, 1'b0, 2'd0, 9'h035}, 1'b1, "R10 R8 char");
    run_frame({3'd0, 1'b0, 1'b0, 1'b0, 2'd2, 9'h03C}, 1'b1, "R10 R8 R7 header");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule